// File: doc/BRIEF.md
# Read-to-Clear Interrupt Flag Controller

This block holds the interrupt status and enable logic of a clock/calendar peripheral. Three event sources feed it single-cycle pulses: a periodic tick, an alarm match and an update-ended event. Each event sets a sticky flag. Each source also has an enable bit, and the block drives an active-low interrupt request while any enabled source has its flag set. Software can use the request line, or it can poll the flags with every enable cleared.

A small register port accesses two registers. A write to the control register loads the three enables. A read of the status register is a transaction that spans several cycles and is marked by a start strobe and an end strobe. On the start strobe the block captures the status value: the three flags plus a summary bit that mirrors the request line. That value stays frozen for the whole read. On the end strobe every flag clears. An event that arrives while a read is open is held in a pending store and posted to its flag once the read has closed, so the next read reports it.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: An event pulse sets its flag whatever its enable holds. Status bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. The flag becomes visible in the status read that follows.
- R2: A write with `wr_addr_i`=0 (control register) loads the periodic, alarm and update-ended enables from `wr_data_i` bits 6, 5 and 4. The other data bits have no effect.
- R3: `irq_n_o` is 0 exactly when at least one source has both its flag and its enable set. Otherwise it is 1.
- R4: Setting an enable while its flag is already set drives `irq_n_o` low in the cycle right after the write, however long ago the event occurred.
- R5: A start strobe while no read is open captures the status value. Bit 7 is 1 exactly when `irq_n_o` was low in the start cycle. Bits 6 to 4 hold the flags. Bits 3 to 0 are 0. `rd_data_o` shows this value from the next cycle until the end strobe, unchanged.
- R6: An end strobe during an open read clears all three flags and closes the read. As a result `irq_n_o` returns high unless a pending event re-arms it later.
- R7: An event arriving from the start cycle through the end cycle of a read is held. It is applied to its flag in the first cycle with no read open and no start strobe. It never appears in the read that was open when it arrived.
- R8: Two or three flags can be set at once and read together in one status value.
- R9: A write with `wr_addr_i`=1 (status register) changes neither the flags nor the enables.
- R10: While `rst_ni` is low the flags, enables, pending holds and the open-read state are cleared, `irq_n_o` is 1 and `rd_data_o` is 0.
- R11: `rd_data_o` is 0 while no read is open. An end strobe with no read open has no effect. A start strobe during an open read has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_per_i | input | 1 | Periodic tick event pulse |
| evt_alm_i | input | 1 | Alarm match event pulse |
| evt_upd_i | input | 1 | Update-ended event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 8 | Write data |
| rd_start_i | input | 1 | Status read begin strobe |
| rd_end_i | input | 1 | Status read finish strobe |
| rd_data_o | output | 8 | Captured status value during a read, else 0 |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is an event that lands exactly on a read's boundary cycles. Three cases matter: the start cycle, the end cycle, and the cycle right after the end when a new read starts at once and the pending hold has to survive a second read. Directed sequences place each event pulse on each of these cycles. A long random phase then drives short reads back to back with dense event traffic. The behavioural model, compared every cycle, catches any event that is lost or posted early.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC   = 3;
  localparam int DATA_W    = 8;
  localparam int FIELD_LSB = 4;
  localparam int SUM_BIT   = 7;
  localparam int ADDR_W    = 1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 1'b1;
  // source index: 2 periodic, 1 alarm, 0 update-ended (bit FIELD_LSB+index)
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output src_vec_t          en_o
);
  src_vec_t en_q;
  src_vec_t en_d;
  logic     load_en;

  assign load_en = wr_en_i && (wr_addr_i == ADDR_CTRL);

  always_comb begin
    en_d = en_q;
    if (load_en) en_d = wr_data_i[FIELD_LSB +: NUM_SRC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  // R9: a status-address write leaves the enables untouched
  a_r9_stat_write_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_STAT) |=> $stable(en_q));
  // R2: a control write lands its field in the enables
  a_r2_ctrl_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_CTRL) |=> (en_q == $past(wr_data_i[FIELD_LSB +: NUM_SRC])));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import rtc_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  logic     hold_i,
  input  logic     clr_i,
  output src_vec_t flag_o
);
  src_vec_t flag_q;
  src_vec_t pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic flag_d;
    logic pend_d;

    always_comb begin
      flag_d = flag_q[g];
      pend_d = 1'b0;
      if (clr_i) begin
        flag_d = 1'b0;
        pend_d = pend_q[g] | evt_i[g];
      end else if (hold_i) begin
        pend_d = pend_q[g] | evt_i[g];
      end else begin
        flag_d = flag_q[g] | pend_q[g] | evt_i[g];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        flag_q[g] <= flag_d;
        pend_q[g] <= pend_d;
      end
    end

    // R1: an event outside any read sets the flag on the next edge
    a_r1_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hold_i && evt_i[g]) |=> flag_q[g]);
    // R7: an event inside a read is kept in the pending hold
    a_r7_event_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((hold_i || clr_i) && evt_i[g]) |=> pend_q[g]);
    // R7: flags do not move while a read is open
    a_r7_flag_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && !clr_i) |=> $stable(flag_q[g]));
  end

  // R6: finishing a read clears all flags
  a_r6_end_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flag_q == '0));

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_status_snap.sv
module irq_status_snap
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_start_i,
  input  logic              rd_end_i,
  input  src_vec_t          flag_i,
  input  logic              irq_act_i,
  output logic              hold_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              busy_q;
  logic              busy_d;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] snap_d;
  logic [DATA_W-1:0] snap_val;
  logic              capture;

  assign capture = rd_start_i && !busy_q;
  assign clr_o   = rd_end_i && busy_q;
  assign hold_o  = busy_q || rd_start_i;

  always_comb begin
    snap_val = '0;
    snap_val[FIELD_LSB +: NUM_SRC] = flag_i;
    snap_val[SUM_BIT] = irq_act_i;
  end

  always_comb begin
    busy_d = busy_q;
    snap_d = snap_q;
    if (clr_o) begin
      busy_d = 1'b0;
      snap_d = '0;
    end else if (capture) begin
      busy_d = 1'b1;
      snap_d = snap_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      snap_q <= '0;
    end else begin
      busy_q <= busy_d;
      snap_q <= snap_d;
    end
  end

  assign rd_data_o = busy_q ? snap_q : '0;

  // R5: the read value stays frozen while the read is open
  a_r5_snap_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rd_end_i) |=> $stable(rd_data_o));
  // R5: summary bit records the request line at the start cycle
  a_r5_summary_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> (rd_data_o[SUM_BIT] == $past(irq_act_i)));
  // R11: no read open means a zero read bus
  a_r11_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !rd_start_i) |=> (rd_data_o == '0));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_per_i,
  input  logic        evt_alm_i,
  input  logic        evt_upd_i,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        rd_start_i,
  input  logic        rd_end_i,
  output logic [7:0]  rd_data_o,
  output logic        irq_n_o
);
  logic     rst_int_n;
  src_vec_t evt_vec;
  src_vec_t en_vec;
  src_vec_t flag_vec;
  logic     hold;
  logic     clr;
  logic     irq_act;

  assign evt_vec = {evt_per_i, evt_alm_i, evt_upd_i};

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  irq_enable_reg u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_vec)
  );

  irq_flag_bank u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .evt_i  (evt_vec),
    .hold_i (hold),
    .clr_i  (clr),
    .flag_o (flag_vec)
  );

  assign irq_act = |(flag_vec & en_vec);

  irq_status_snap u_snap (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .rd_start_i (rd_start_i),
    .rd_end_i   (rd_end_i),
    .flag_i     (flag_vec),
    .irq_act_i  (irq_act),
    .hold_o     (hold),
    .clr_o      (clr),
    .rd_data_o  (rd_data_o)
  );

  assign irq_n_o = ~irq_act;

  // R4: enabling a source whose flag is already up raises the request next cycle
  a_r4_late_enable: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (wr_en_i && wr_addr_i == ADDR_CTRL && |(wr_data_i[FIELD_LSB +: NUM_SRC] & flag_vec) && !clr)
      |=> !irq_n_o);
  // R10: request inactive while reset is applied
  a_r10_reset_idle: assert property (@(posedge clk_i) !rst_int_n |-> irq_n_o);
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ep, ea, eu, wen, waddr, rs, re;
  logic [7:0] wdat;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  bit [2:0] m_en, m_flag, m_pend;
  bit       m_busy;
  bit [7:0] m_snap;

  always #2 clk = ~clk;

  rtc_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_per_i(ep), .evt_alm_i(ea), .evt_upd_i(eu),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdat),
    .rd_start_i(rs), .rd_end_i(re), .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_irq();
    return |(m_flag & m_en);
  endfunction

  task automatic m_reset();
    m_en = 0; m_flag = 0; m_pend = 0; m_busy = 0; m_snap = 0;
  endtask

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic cyc(string tag, bit [2:0] evt, bit w, bit wa, bit [7:0] wd, bit s, bit e);
    bit [2:0] nf, np, ne;
    bit       nb;
    bit [7:0] ns;
    @(negedge clk);
    {ep, ea, eu} = evt; wen = w; waddr = wa; wdat = wd; rs = s; re = e;
    @(posedge clk);
    ne = m_en; nf = m_flag; np = m_pend; nb = m_busy; ns = m_snap;
    if (w && !wa) ne = wd[6:4];
    if (m_busy && e) begin
      nf = 0; np = m_pend | evt; nb = 0;
    end else if (m_busy || s) begin
      np = m_pend | evt;
      if (!m_busy) begin nb = 1; ns = {m_irq(), m_flag, 4'b0}; end
    end else begin
      nf = m_flag | m_pend | evt; np = 0;
    end
    m_en = ne; m_flag = nf; m_pend = np; m_busy = nb; m_snap = ns;
    #1;
    chk({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, ~m_irq()});
    chk({tag, " rd_data"}, rd_data, m_busy ? m_snap : 8'h00);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 3'b000, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic wr(string tag, bit a, bit [7:0] d);
    cyc(tag, 3'b000, 1, a, d, 0, 0);
  endtask

  task automatic ev(string tag, bit [2:0] e);
    cyc(tag, e, 0, 0, 8'h00, 0, 0);
  endtask

  // full read: start, gap cycles, end; returns the value seen mid-read
  task automatic rd(string tag, int gap, output bit [7:0] val);
    cyc(tag, 3'b000, 0, 0, 8'h00, 1, 0);
    val = rd_data;
    for (int i = 0; i < gap; i++) cyc(tag, 3'b000, 0, 0, 8'h00, 0, 0);
    cyc(tag, 3'b000, 0, 0, 8'h00, 0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    bit [7:0] v;
    {ep, ea, eu, wen, waddr, rs, re} = '0;
    wdat = 8'h00;
    m_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 reset irq_n", {7'b0, irq_n}, 8'h01);
    chk("R10 reset rd_data", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle("R10", 4);

    // R1: flags set with enables cleared, request stays off
    ev("R1", 3'b100);
    chk("R1 irq_n no enable", {7'b0, irq_n}, 8'h01);
    rd("R1", 2, v);
    chk("R1 periodic flag bit6", v, 8'h40);
    ev("R1", 3'b001); rd("R1", 0, v);
    chk("R1 update flag bit4", v, 8'h10);

    // R2 / R4: late enable of a pending flag
    ev("R4", 3'b010);
    idle("R4", 3);
    chk("R4 irq before enable", {7'b0, irq_n}, 8'h01);
    wr("R4", 0, 8'h2F);           // bit5 set, other bits junk
    chk("R4 irq after enable", {7'b0, irq_n}, 8'h00);
    rd("R5", 1, v);
    chk("R5 summary and alarm", v, 8'hA0);
    chk("R6 irq released", {7'b0, irq_n}, 8'h01);
    wr("R2", 0, 8'h8F);           // bits 6:4 zero, others one
    ev("R2", 3'b111);
    chk("R2 junk bits do not enable", {7'b0, irq_n}, 8'h01);

    // R9: status write ignored
    wr("R9", 1, 8'h00);
    wr("R9", 1, 8'hFF);
    rd("R9", 0, v);
    chk("R9 flags kept R8 all three", v, 8'h70);
    wr("R9", 1, 8'hFF);
    ev("R9", 3'b100);
    chk("R9 enables not loaded", {7'b0, irq_n}, 8'h01);
    rd("R9", 0, v);

    // R7: events on start, middle, end, and during back-to-back read
    wr("R7", 0, 8'h70);
    cyc("R7", 3'b100, 0, 0, 8'h00, 1, 0);   // start + periodic
    chk("R7 start event hidden", rd_data, 8'h00);
    cyc("R7", 3'b010, 0, 0, 8'h00, 0, 0);   // mid + alarm
    cyc("R7", 3'b001, 0, 0, 8'h00, 0, 1);   // end + update
    chk("R7 held past end", {7'b0, irq_n}, 8'h01);
    cyc("R7", 3'b000, 0, 0, 8'h00, 1, 0);   // restart at once
    chk("R7 not in back-to-back read", rd_data, 8'h00);
    cyc("R7", 3'b000, 0, 0, 8'h00, 0, 1);
    idle("R7", 1);
    chk("R7 applied after reads", {7'b0, irq_n}, 8'h00);
    rd("R8", 0, v);
    chk("R8 three flags together", v, 8'hF0);

    // R11: stray strobes
    cyc("R11", 3'b000, 0, 0, 8'h00, 0, 1);
    ev("R11", 3'b010);
    cyc("R11", 3'b000, 0, 0, 8'h00, 1, 0);
    cyc("R11", 3'b000, 0, 0, 8'h00, 1, 0);
    chk("R11 second start ignored", rd_data, 8'hA0);
    cyc("R11", 3'b000, 0, 0, 8'h00, 0, 1);
    chk("R11 idle zero", rd_data, 8'h00);

    // R3: random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] r;
      r = $urandom;
      cyc("R3", r[2:0] & {r[3], r[4], r[5]}, r[6] & r[7], r[8], r[15:8], r[16] & r[17], r[18] & r[19]);
    end

    // R10: reset asserted mid-run
    ev("R10", 3'b111);
    wr("R10", 0, 8'h70);
    @(negedge clk); rst_n = 1'b0; m_reset();
    #1;
    chk("R10 async irq_n", {7'b0, irq_n}, 8'h01);
    chk("R10 async rd_data", rd_data, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    idle("R10", 4);
    rd("R10", 0, v);
    chk("R10 flags cleared", v, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule